// File: doc/BRIEF.md
# Rotating Predicate Register File

This block holds sixty-four one-bit predicates that decide whether each instruction in a wide-issue core is allowed to execute. The lowest sixteen logical predicates are fixed in place. Logical predicate 0 is a constant true, so an instruction that must always run can name it. The upper forty-eight logical predicates sit on a circular window. A rotation base moves that window, so a software-pipelined loop can refer to the same logical name in every iteration and still reach a fresh physical bit.

One read port takes a qualifying-predicate index and returns, one clock later, an execute-enable bit equal to that predicate. Two single-bit write ports take compare results. A pair of group ports reads or writes eight logically consecutive predicates as one byte. A rotate-step pulse moves the window down by one position. Every access goes through the logical-to-physical mapping of the current rotation base.

Top module: `pred_rot_file`

## Requirements
- R1: While `rst` is high, every logical predicate except 0 is cleared, the rotation base returns to 0, and both `qp_exec_en` and `grp_rdata` are driven to 0.
- R2: Logical predicate 0 always reads as 1. A compare write or a group write to it has no effect. This includes bit 0 of group 0.
- R3: Logical predicates 1 to 15 map to the physical bit of the same number. A rotate step leaves their values unchanged.
- R4: For a logical index p from 16 to 63, the physical bit is 16 + ((p − 16 + base) mod 48), where base is the rotation base. After one step, logical p therefore reads the value that logical p−1 held before the step, and logical 16 reads what logical 63 held.
- R5: Each cycle with `rot_step` high lowers the base by one, modulo 48, so 0 wraps to 47. After 48 steps the logical view is the same as it was before them.
- R6: `qp_exec_en` is registered. On the edge after `qp_sel` is presented, it takes the value of that logical predicate as it stood before any write in that same cycle.
- R7: A compare port with its enable high writes its value bit to the logical predicate its select names. When both ports name the same predicate, the value of port 0 is stored.
- R8: A group write with select g and data d stores d[k] into logical predicate 8g+k for k = 0 to 7, through the rotation mapping.
- R9: A group read with select g returns, on the next edge, logical predicate 8g+k in bit k of `grp_rdata`, with the state as it stood before any write in that cycle.
- R10: When a compare write and a group write reach the same predicate in the same cycle, the compare value is stored.
- R11: Writes made in a cycle where `rot_step` is high use the base from before the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rot_step | input | 1 | Move the rotation window down by one position |
| qp_sel | input | 6 | Logical index of the qualifying predicate |
| qp_exec_en | output | 1 | Registered value of the selected predicate |
| cw0_en | input | 1 | Compare write port 0 enable |
| cw0_sel | input | 6 | Compare write port 0 logical index |
| cw0_val | input | 1 | Compare write port 0 value |
| cw1_en | input | 1 | Compare write port 1 enable |
| cw1_sel | input | 6 | Compare write port 1 logical index |
| cw1_val | input | 1 | Compare write port 1 value |
| grp_we | input | 1 | Group write enable |
| grp_wsel | input | 3 | Group write select |
| grp_wdata | input | 8 | Group write data, bit k to logical 8g+k |
| grp_rsel | input | 3 | Group read select |
| grp_rdata | output | 8 | Registered group read data |

## Verification
Each of the eight groups is loaded with a distinct byte, and the whole file is then read back both through the single-bit port and by group. This separates errors in bit order from errors in group decode. The bench then steps the base fifty times and reads the whole file after every step. This exposes an off-by-one in the mapping, a missing wrap at 0, and any rotation that disturbs the static region; the forty-eighth step must restore the starting view. A sweep of the compare ports over all 64 indices, with same-index collisions mixed in, tells port priority apart from write order. Writes that land on predicate 0, that overlap a group write, or that fall in the same cycle as a rotate step check the remaining ordering rules.

// File: rtl/pred_pkg.sv
package pred_pkg;
  localparam int unsigned PRED_NUM_DEF   = 64;
  localparam int unsigned PRED_STATIC_DEF = 16;
  localparam int unsigned PRED_GRP_W_DEF  = 8;

  function automatic bit is_pow2(input int n);
    return (n > 0) && ((n & (n - 1)) == 0);
  endfunction
endpackage

// File: rtl/pred_idx_map.sv
module pred_idx_map #(
  parameter int NUM    = 64,
  parameter int STATIC = 16,
  parameter int IDX_W  = 6,
  parameter int RRB_W  = 6
) (
  input  logic [IDX_W-1:0] log_idx,
  input  logic [RRB_W-1:0] rrb,
  output logic [IDX_W-1:0] phys_idx
);
  localparam int ROT = NUM - STATIC;
  localparam int SW  = IDX_W + 1;

  logic [IDX_W-1:0] rot_phys;

  generate
    if (pred_pkg::is_pow2(ROT)) begin : g_pow2
      localparam int RW = $clog2(ROT);
      logic [RW-1:0] wrap;
      always_comb begin
        wrap     = RW'(log_idx - IDX_W'(STATIC) + IDX_W'(rrb));
        rot_phys = IDX_W'(wrap) + IDX_W'(STATIC);
      end
    end else begin : g_mod
      logic [SW-1:0] off;
      always_comb begin
        off = {1'b0, log_idx} - SW'(STATIC) + SW'(rrb);
        if (off >= SW'(ROT)) off = off - SW'(ROT);
        rot_phys = IDX_W'(off + SW'(STATIC));
      end
    end
  endgenerate

  always_comb begin
    if (log_idx < IDX_W'(STATIC)) phys_idx = log_idx;
    else                          phys_idx = rot_phys;
  end
endmodule

// File: rtl/pred_rrb_ctr.sv
module pred_rrb_ctr #(
  parameter int ROT   = 48,
  parameter int RRB_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [RRB_W-1:0] rrb
);
  logic [RRB_W-1:0] rrb_q;

  always_ff @(posedge clk) begin
    if (rst)                    rrb_q <= '0;
    else if (step) begin
      if (rrb_q == '0)          rrb_q <= RRB_W'(ROT - 1);
      else                      rrb_q <= rrb_q - RRB_W'(1);
    end
  end

  assign rrb = rrb_q;

  // R4
  rrb_range_chk: assert property (@(posedge clk) disable iff (rst)
    rrb_q < RRB_W'(ROT));

  // R5
  rrb_step_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> (($past(rrb_q) == '0) ? (rrb_q == RRB_W'(ROT - 1))
                                   : (rrb_q == $past(rrb_q) - RRB_W'(1))));

  // R5
  rrb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(rrb_q));
endmodule

// File: rtl/pred_bits.sv
module pred_bits #(
  parameter int NUM   = 64,
  parameter int IDX_W = 6,
  parameter int GW    = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      grp_we,
  input  logic [GW-1:0][IDX_W-1:0]  grp_wphys,
  input  logic [GW-1:0]             grp_wdata,
  input  logic                      we0,
  input  logic [IDX_W-1:0]          phys0,
  input  logic                      val0,
  input  logic                      we1,
  input  logic [IDX_W-1:0]          phys1,
  input  logic                      val1,
  input  logic [IDX_W-1:0]          rd_phys,
  input  logic [GW-1:0][IDX_W-1:0]  grp_rphys,
  output logic                      rd_bit,
  output logic [GW-1:0]             grp_rbits
);
  logic [NUM-1:0] bits_q;
  logic [NUM-1:0] bits_d;

  always_comb begin
    bits_d = bits_q;
    if (grp_we) begin
      for (int k = 0; k < GW; k++) bits_d[grp_wphys[k]] = grp_wdata[k];
    end
    if (we1) bits_d[phys1] = val1;
    if (we0) bits_d[phys0] = val0;
    bits_d[0] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q    <= {{(NUM-1){1'b0}}, 1'b1};
      rd_bit    <= 1'b0;
      grp_rbits <= '0;
    end else begin
      bits_q <= bits_d;
      rd_bit <= bits_q[rd_phys];
      for (int k = 0; k < GW; k++) grp_rbits[k] <= bits_q[grp_rphys[k]];
    end
  end

  // R7
  port0_store_chk: assert property (@(posedge clk) disable iff (rst)
    (we0 && phys0 != '0) |=> (bits_q[$past(phys0)] == $past(val0)));
endmodule

// File: rtl/pred_rot_file.sv
module pred_rot_file #(
  parameter int NUM_PRED   = pred_pkg::PRED_NUM_DEF,
  parameter int STATIC_CNT = pred_pkg::PRED_STATIC_DEF,
  parameter int GRP_W      = pred_pkg::PRED_GRP_W_DEF
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rot_step,
  input  logic [$clog2(NUM_PRED)-1:0] qp_sel,
  output logic                        qp_exec_en,
  input  logic                        cw0_en,
  input  logic [$clog2(NUM_PRED)-1:0] cw0_sel,
  input  logic                        cw0_val,
  input  logic                        cw1_en,
  input  logic [$clog2(NUM_PRED)-1:0] cw1_sel,
  input  logic                        cw1_val,
  input  logic                        grp_we,
  input  logic [$clog2(NUM_PRED/GRP_W)-1:0] grp_wsel,
  input  logic [GRP_W-1:0]            grp_wdata,
  input  logic [$clog2(NUM_PRED/GRP_W)-1:0] grp_rsel,
  output logic [GRP_W-1:0]            grp_rdata
);
  localparam int IDX_W   = $clog2(NUM_PRED);
  localparam int ROT_CNT = NUM_PRED - STATIC_CNT;
  localparam int RRB_W   = $clog2(ROT_CNT);

  logic [RRB_W-1:0]              rrb;
  logic [IDX_W-1:0]              qp_phys, w0_phys, w1_phys;
  logic [GRP_W-1:0][IDX_W-1:0]   gw_log, gw_phys, gr_log, gr_phys;
  logic                          qp_bit;
  logic [GRP_W-1:0]              grp_bits;

  pred_rrb_ctr #(.ROT(ROT_CNT), .RRB_W(RRB_W)) rrb_i (
    .clk(clk), .rst(rst), .step(rot_step), .rrb(rrb));

  pred_idx_map #(.NUM(NUM_PRED), .STATIC(STATIC_CNT), .IDX_W(IDX_W), .RRB_W(RRB_W))
    map_qp_i (.log_idx(qp_sel), .rrb(rrb), .phys_idx(qp_phys));
  pred_idx_map #(.NUM(NUM_PRED), .STATIC(STATIC_CNT), .IDX_W(IDX_W), .RRB_W(RRB_W))
    map_w0_i (.log_idx(cw0_sel), .rrb(rrb), .phys_idx(w0_phys));
  pred_idx_map #(.NUM(NUM_PRED), .STATIC(STATIC_CNT), .IDX_W(IDX_W), .RRB_W(RRB_W))
    map_w1_i (.log_idx(cw1_sel), .rrb(rrb), .phys_idx(w1_phys));

  generate
    for (genvar k = 0; k < GRP_W; k++) begin : g_lane
      assign gw_log[k] = IDX_W'(int'(grp_wsel) * GRP_W + k);
      assign gr_log[k] = IDX_W'(int'(grp_rsel) * GRP_W + k);
      pred_idx_map #(.NUM(NUM_PRED), .STATIC(STATIC_CNT), .IDX_W(IDX_W), .RRB_W(RRB_W))
        map_gw_i (.log_idx(gw_log[k]), .rrb(rrb), .phys_idx(gw_phys[k]));
      pred_idx_map #(.NUM(NUM_PRED), .STATIC(STATIC_CNT), .IDX_W(IDX_W), .RRB_W(RRB_W))
        map_gr_i (.log_idx(gr_log[k]), .rrb(rrb), .phys_idx(gr_phys[k]));
    end
  endgenerate

  pred_bits #(.NUM(NUM_PRED), .IDX_W(IDX_W), .GW(GRP_W)) bits_i (
    .clk(clk), .rst(rst),
    .grp_we(grp_we), .grp_wphys(gw_phys), .grp_wdata(grp_wdata),
    .we0(cw0_en), .phys0(w0_phys), .val0(cw0_val),
    .we1(cw1_en), .phys1(w1_phys), .val1(cw1_val),
    .rd_phys(qp_phys), .grp_rphys(gr_phys),
    .rd_bit(qp_bit), .grp_rbits(grp_bits));

  assign qp_exec_en = qp_bit;
  assign grp_rdata  = grp_bits;

  // R2
  p0_true_chk: assert property (@(posedge clk) disable iff (rst)
    (qp_sel == '0) |=> qp_exec_en);

  // R3
  region_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (cw0_sel >= IDX_W'(STATIC_CNT)) == (w0_phys >= IDX_W'(STATIC_CNT)));

  // R3
  static_map_chk: assert property (@(posedge clk) disable iff (rst)
    (qp_sel < IDX_W'(STATIC_CNT)) |-> (qp_phys == qp_sel));
endmodule

// File: tb/pred_rot_file_tb_top.sv
`timescale 1ns/1ps
module pred_rot_file_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rot_step = 0, cw0_en = 0, cw0_val = 0, cw1_en = 0, cw1_val = 0, grp_we = 0;
  logic [5:0] qp_sel = 0, cw0_sel = 0, cw1_sel = 0;
  logic [2:0] grp_wsel = 0, grp_rsel = 0;
  logic [7:0] grp_wdata = 0;
  logic       qp_exec_en;
  logic [7:0] grp_rdata;

  int errors = 0;
  int checks = 0;
  logic L [64];
  logic snap [64];
  logic exp_q;
  logic [7:0] exp_g;

  always #2.5 clk = ~clk;

  pred_rot_file dut_i (
    .clk(clk), .rst(rst), .rot_step(rot_step), .qp_sel(qp_sel), .qp_exec_en(qp_exec_en),
    .cw0_en(cw0_en), .cw0_sel(cw0_sel), .cw0_val(cw0_val),
    .cw1_en(cw1_en), .cw1_sel(cw1_sel), .cw1_val(cw1_val),
    .grp_we(grp_we), .grp_wsel(grp_wsel), .grp_wdata(grp_wdata),
    .grp_rsel(grp_rsel), .grp_rdata(grp_rdata));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] grp_of(input int g);
    logic [7:0] v;
    for (int k = 0; k < 8; k++) v[k] = L[g*8+k];
    return v;
  endfunction

  task automatic cyc(input bit gw, input int gws, input logic [7:0] gd,
                     input bit w0, input int i0, input bit v0,
                     input bit w1, input int i1, input bit v1,
                     input bit st, input int rq, input int gr);
    logic t63;
    grp_we = gw; grp_wsel = 3'(gws); grp_wdata = gd;
    cw0_en = w0; cw0_sel = 6'(i0); cw0_val = v0;
    cw1_en = w1; cw1_sel = 6'(i1); cw1_val = v1;
    rot_step = st; qp_sel = 6'(rq); grp_rsel = 3'(gr);
    exp_q = L[rq];
    exp_g = grp_of(gr);
    @(posedge clk); #1;
    if (gw) for (int k = 0; k < 8; k++) L[gws*8+k] = gd[k];
    if (w1) L[i1] = v1;
    if (w0) L[i0] = v0;
    L[0] = 1'b1;
    if (st) begin
      t63 = L[63];
      for (int p = 63; p > 16; p--) L[p] = L[p-1];
      L[16] = t63;
    end
    grp_we = 0; cw0_en = 0; cw1_en = 0; rot_step = 0;
  endtask

  task automatic idle_rd(input int rq, input int gr);
    cyc(0, 0, 8'h00, 0, 0, 0, 0, 0, 0, 0, rq, gr);
  endtask

  task automatic verify_groups(input string why);
    for (int g = 0; g < 8; g++) begin
      idle_rd(0, g);
      chk(g < 2 ? {"R3 ", why} : {"R4 ", why}, grp_rdata, exp_g);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int p = 0; p < 64; p++) L[p] = (p == 0);
    repeat (3) @(posedge clk);
    #1;
    // R1 outputs held low during reset
    chk("R1 exec_en in reset", {7'b0, qp_exec_en}, 8'h00);
    chk("R1 grp_rdata in reset", grp_rdata, 8'h00);
    rst = 0;
    // R1 cleared contents, R2 predicate 0 true
    for (int g = 0; g < 8; g++) begin
      idle_rd(0, g);
      chk("R1 group after reset", grp_rdata, exp_g);
    end
    // R8 group writes, including 0 into bit 0 of group 0 (R2)
    for (int g = 0; g < 8; g++)
      cyc(1, g, 8'((g*73+29) ^ (g << 5)) & (g == 0 ? 8'hFE : 8'hFF),
          0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int g = 0; g < 8; g++) begin
      idle_rd(0, g);
      chk("R9 group readback", grp_rdata, exp_g);
    end
    for (int p = 0; p < 64; p++) begin
      idle_rd(p, 0);
      chk(p == 0 ? "R2 p0 via qp" : "R6 qp readback", {7'b0, qp_exec_en}, {7'b0, exp_q});
    end
    // R5 / R4 rotation sweep
    for (int p = 0; p < 64; p++) snap[p] = L[p];
    for (int s = 1; s <= 50; s++) begin
      cyc(0, 0, 8'h00, 0, 0, 0, 0, 0, 0, 1, 0, 0);
      verify_groups("after step");
      if (s == 48) begin
        for (int g = 0; g < 8; g++) begin
          logic [7:0] sv;
          for (int k = 0; k < 8; k++) sv[k] = snap[g*8+k];
          idle_rd(0, g);
          chk("R5 wrap after 48 steps", grp_rdata, sv);
        end
      end
    end
    // R7 compare port sweep with collisions, R6 read-before-write
    for (int i = 0; i < 64; i++) begin
      bit nv;
      int j;
      nv = ~L[i];
      j = ((i % 4) == 0) ? i : (i*7 + 3) % 64;
      cyc(0, 0, 8'h00, 1, i, nv, 1, j, ~nv, 0, i, 0);
      chk("R6 qp shows pre-write", {7'b0, qp_exec_en}, {7'b0, exp_q});
      idle_rd(i, 0);
      chk(i == 0 ? "R2 write to p0 ignored" : "R7 port0 value stored",
          {7'b0, qp_exec_en}, {7'b0, exp_q});
      idle_rd(j, 0);
      chk("R7 port1 target", {7'b0, qp_exec_en}, {7'b0, exp_q});
    end
    // R10 compare write overrides group write
    cyc(1, 3, 8'hFF, 1, 26, 0, 1, 31, 0, 0, 0, 0);
    idle_rd(0, 3);
    chk("R10 compare over group", grp_rdata, exp_g);
    chk("R10 expected pattern", exp_g, 8'h7B);
    // R11 writes with same-cycle rotate use pre-step base
    cyc(0, 0, 8'h00, 1, 40, 1, 1, 63, 0, 1, 0, 0);
    idle_rd(41, 0);
    chk("R11 write then step, p41", {7'b0, qp_exec_en}, 8'h01);
    idle_rd(16, 0);
    chk("R11 p63 moved to p16", {7'b0, qp_exec_en}, 8'h00);
    cyc(1, 5, 8'hA5, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    idle_rd(0, 5);
    chk("R11 group write then step", grp_rdata, exp_g);
    verify_groups("final");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule